// File: doc/BRIEF.md
# Floating-Point Special-Value Fixup Unit

This unit takes one double-precision source operand, sorts it into one of eight classes, and uses that class to choose a 4-bit replacement token from a 32-bit control word that software programs at run time. The token decides what the result holds. It can be the previous destination value, the source itself, a quieted copy of the source, or one of a set of fixed special constants: infinities, signed zeros, ±1, one half, ninety, a quarter turn in radians, and the largest finite magnitudes.

A typical use is to rewrite a special value without a branch. With the control word 0x00000700, every zero of either sign becomes −0 and every other value keeps the destination. With 0x00450000, the two infinities swap places. An optional denormals-are-zero control flushes subnormal sources to a zero of the same sign. The flush happens before classification and also applies to the value that the pass-through token forwards.

The result is registered. A request strobed on `in_valid` appears on `res_out` in the next cycle, together with `res_valid`.

Top module: `fp_fixup_unit`

## Requirements
- R1: The source is classified with these class numbers: quiet NaN = 0, signalling NaN = 1, zero of either sign = 2, one = 3, −infinity = 4, +infinity = 5, other negative = 6, other positive = 7. A NaN (exponent all ones, mantissa nonzero) is quiet when mantissa bit 51 is 1.
- R2: The token for class k is taken from control bits 4k+3..4k. For example, the zero class reads bits 11..8.
- R3: When `daz_en` is 1, a subnormal source (exponent 0, mantissa nonzero) is replaced by a zero with the same sign, both for classification and for the pass-through token. When `daz_en` is 0, a subnormal is classified as class 6 or class 7 according to its sign bit.
- R4: Token 0x0 yields `dst_in`. Token 0x1 yields the source after any flush.
- R5: Token 0x2 yields the source NaN with bit 51 set and its sign and other payload bits kept; for a non-NaN source it yields 0xFFF8000000000000. Token 0x3 always yields 0xFFF8000000000000.
- R6: Token 0x4 yields 0xFFF0000000000000 and token 0x5 yields 0x7FF0000000000000. Token 0x6 yields −infinity when the flushed source's sign bit is 1, and +infinity otherwise.
- R7: Tokens 0x7..0xF yield, in order: 0x8000000000000000, 0x0, 0xBFF0000000000000, 0x3FF0000000000000, 0x3FE0000000000000, 0x4056800000000000, 0x3FF921FB54442D18, 0x7FEFFFFFFFFFFFFF, 0xFFEFFFFFFFFFFFFF.
- R8: A request taken when `in_valid` is 1 appears on `res_out` in the next cycle, and `res_valid` is 1 in that same cycle. A cycle with `in_valid` 0 is followed by a cycle with `res_valid` 0.
- R9: While `in_valid` is 0, `res_out` keeps its value whatever the other inputs do.
- R10: After a synchronous active-low reset, `res_valid` is 0 and `res_out` is 0.
- R11: Only the exact pattern 0x3FF0000000000000 is in class 3. The value −1.0 falls in class 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dst_in | input | 64 | Destination operand, returned by token 0x0 |
| src_in | input | 64 | Source operand that is classified |
| ctrl_word | input | 32 | Eight 4-bit tokens, one per class |
| daz_en | input | 1 | Flush subnormal sources to signed zero |
| res_out | output | 64 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after the request |

## Verification
The bench builds the unit with its default parameters: an 11-bit exponent and a 52-bit mantissa. At that width every constant can be checked against its exact binary64 pattern. These widths also let the bench step every class through every token, with the flush control both on and off. Random operands that are biased toward NaNs, infinities, subnormals and ±1.0 then reach the borders between classes, and in particular the border between a flushed subnormal and a true value.

// File: rtl/fixup_pkg.sv
// Package: class and token codes for the fixup unit.
// Assumes: IEEE-style binary layout {sign, exponent, mantissa}.
package fixup_pkg;

    localparam int TOK_W  = 4;
    localparam int CAT_N  = 8;
    localparam int CAT_W  = $clog2(CAT_N);
    localparam int CTRL_W = CAT_N * TOK_W;

    typedef enum logic [2:0] {
        CAT_QNAN = 3'd0,
        CAT_SNAN = 3'd1,
        CAT_ZERO = 3'd2,
        CAT_ONE  = 3'd3,
        CAT_NINF = 3'd4,
        CAT_PINF = 3'd5,
        CAT_NEG  = 3'd6,
        CAT_POS  = 3'd7
    } fix_cat_e;

    typedef enum logic [3:0] {
        TOK_DST    = 4'h0,
        TOK_SRC    = 4'h1,
        TOK_QUIET  = 4'h2,
        TOK_INDEF  = 4'h3,
        TOK_NINF   = 4'h4,
        TOK_PINF   = 4'h5,
        TOK_SGNINF = 4'h6,
        TOK_NZERO  = 4'h7,
        TOK_PZERO  = 4'h8,
        TOK_NONE   = 4'h9,
        TOK_PONE   = 4'hA,
        TOK_HALF   = 4'hB,
        TOK_NINETY = 4'hC,
        TOK_QTURN  = 4'hD,
        TOK_PMAX   = 4'hE,
        TOK_NMAX   = 4'hF
    } fix_tok_e;

    // Fraction of pi/2 (binary64 width); narrower formats take its top bits.
    localparam logic [51:0] QTURN_FRAC52 = 52'h921FB54442D18;

endpackage

// File: rtl/fixup_classify.sv
// Module: fixup_classify
// Applies the optional subnormal flush and sorts the source into one of
// the eight classes. Assumes EXP_W >= 2 and MAN_W >= 1.
module fixup_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int FP_W = 1 + EXP_W + MAN_W
) (
    input  logic [FP_W-1:0] src_raw,
    input  logic            daz_en,
    output logic [FP_W-1:0] src_eff,
    output logic [2:0]      cat,
    output logic            src_is_nan
);
    import fixup_pkg::*;

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [FP_W-1:0] ONE_PAT =
        {1'b0, EXP_W'(BIAS), {MAN_W{1'b0}}};

    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
    logic             exp_max;

    // Flush a subnormal to a zero of the same sign when requested.
    always_comb begin
        if (daz_en && (src_raw[FP_W-2 -: EXP_W] == '0) && (src_raw[MAN_W-1:0] != '0))
            src_eff = {src_raw[FP_W-1], {(FP_W-1){1'b0}}};
        else
            src_eff = src_raw;
    end

    assign sgn     = src_eff[FP_W-1];
    assign expo    = src_eff[FP_W-2 -: EXP_W];
    assign man     = src_eff[MAN_W-1:0];
    assign exp_max = &expo;

    // Pick the class; priority NaN, zero, one, infinity, signed value.
    always_comb begin
        src_is_nan = exp_max && (man != '0);
        if (src_is_nan)
            cat = man[MAN_W-1] ? CAT_QNAN : CAT_SNAN;
        else if (src_eff[FP_W-2:0] == '0)
            cat = CAT_ZERO;
        else if (src_eff == ONE_PAT)
            cat = CAT_ONE;
        else if (exp_max)
            cat = sgn ? CAT_NINF : CAT_PINF;
        else
            cat = sgn ? CAT_NEG : CAT_POS;
    end

    // Guard: NaN classes only for an all-ones exponent of the raw source (R1).
    always_comb begin
        if (cat == CAT_QNAN || cat == CAT_SNAN)
            a_r1_nan_needs_max_exp: assert (&src_raw[FP_W-2 -: EXP_W]);
    end

    // Guard: a flushed subnormal always lands in the zero class (R3).
    always_comb begin
        if (daz_en && src_raw[FP_W-2 -: EXP_W] == '0)
            a_r3_flush_is_zero: assert (cat == CAT_ZERO);
    end

endmodule

// File: rtl/fixup_tok_pick.sv
// Module: fixup_tok_pick
// Slices the packed control word into per-class tokens and selects the
// token of the current class. Assumes CAT_N is a power of two.
module fixup_tok_pick #(
    parameter int TOK_W = 4,
    parameter int CAT_N = 8,
    localparam int CAT_W  = $clog2(CAT_N),
    localparam int CTRL_W = TOK_W * CAT_N
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [CAT_W-1:0]  cat,
    output logic [TOK_W-1:0]  tok
);
    logic [TOK_W-1:0] slot [CAT_N];

    // One slice per class: class k owns bits TOK_W*k+TOK_W-1 .. TOK_W*k.
    for (genvar k = 0; k < CAT_N; k++) begin : g_slot
        assign slot[k] = ctrl_word[k*TOK_W +: TOK_W];
    end

    // Select the slice addressed by the class number.
    assign tok = slot[cat];

endmodule

// File: rtl/fixup_value_gen.sv
// Module: fixup_value_gen
// Turns a token into the replacement value. Constants are derived from
// the format widths. Assumes MAN_W <= 52 for the pi/2 fraction and MAN_W >= 6.
module fixup_value_gen #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int FP_W = 1 + EXP_W + MAN_W
) (
    input  logic [3:0]      tok,
    input  logic [FP_W-1:0] dst,
    input  logic [FP_W-1:0] src_eff,
    input  logic            src_is_nan,
    output logic [FP_W-1:0] value
);
    import fixup_pkg::*;

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] E_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] E_BIAS = EXP_W'(BIAS);
    localparam logic [MAN_W-1:0] M_ZERO = '0;
    localparam logic [MAN_W-1:0] M_QBIT = {1'b1, {(MAN_W-1){1'b0}}};

    localparam logic [FP_W-1:0] C_PINF   = {1'b0, E_ONES, M_ZERO};
    localparam logic [FP_W-1:0] C_NINF   = {1'b1, E_ONES, M_ZERO};
    localparam logic [FP_W-1:0] C_INDEF  = {1'b1, E_ONES, M_QBIT};
    localparam logic [FP_W-1:0] C_PONE   = {1'b0, E_BIAS, M_ZERO};
    localparam logic [FP_W-1:0] C_NONE   = {1'b1, E_BIAS, M_ZERO};
    localparam logic [FP_W-1:0] C_HALF   = {1'b0, EXP_W'(BIAS - 1), M_ZERO};
    localparam logic [FP_W-1:0] C_NINETY =
        {1'b0, EXP_W'(BIAS + 6), 6'b011010, {(MAN_W-6){1'b0}}};
    localparam logic [FP_W-1:0] C_QTURN  =
        {1'b0, E_BIAS, QTURN_FRAC52[51 -: MAN_W]};
    localparam logic [FP_W-1:0] C_PMAX   =
        {1'b0, E_ONES - EXP_W'(1), {MAN_W{1'b1}}};
    localparam logic [FP_W-1:0] C_NMAX   =
        {1'b1, E_ONES - EXP_W'(1), {MAN_W{1'b1}}};

    logic [FP_W-1:0] quieted;

    // Quiet a NaN by setting the top mantissa bit; non-NaN gets the default.
    assign quieted = src_is_nan ? (src_eff | {{(FP_W-MAN_W){1'b0}}, M_QBIT})
                                : C_INDEF;

    // Map each token to its replacement value.
    always_comb begin
        unique case (fix_tok_e'(tok))
            TOK_DST:    value = dst;
            TOK_SRC:    value = src_eff;
            TOK_QUIET:  value = quieted;
            TOK_INDEF:  value = C_INDEF;
            TOK_NINF:   value = C_NINF;
            TOK_PINF:   value = C_PINF;
            TOK_SGNINF: value = src_eff[FP_W-1] ? C_NINF : C_PINF;
            TOK_NZERO:  value = {1'b1, {(FP_W-1){1'b0}}};
            TOK_PZERO:  value = '0;
            TOK_NONE:   value = C_NONE;
            TOK_PONE:   value = C_PONE;
            TOK_HALF:   value = C_HALF;
            TOK_NINETY: value = C_NINETY;
            TOK_QTURN:  value = C_QTURN;
            TOK_PMAX:   value = C_PMAX;
            TOK_NMAX:   value = C_NMAX;
            default:    value = dst;
        endcase
    end

    // Guard: a quieted NaN always carries the quiet bit (R5).
    always_comb begin
        if (tok == TOK_QUIET)
            a_r5_quiet_bit_set: assert (value[MAN_W-1] && (&value[FP_W-2 -: EXP_W]));
    end

endmodule

// File: rtl/fp_fixup_unit.sv
// Module: fp_fixup_unit (top)
// Classifies the source, looks up the class token in the control word,
// forms the replacement value and registers it with a valid flag.
// Assumes a synchronous active-low reset and one request per cycle.
module fp_fixup_unit #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int FP_W   = 1 + EXP_W + MAN_W,
    localparam int CTRL_W = fixup_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   dst_in,
    input  logic [FP_W-1:0]   src_in,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              daz_en,
    output logic [FP_W-1:0]   res_out,
    output logic              res_valid
);
    import fixup_pkg::*;

    logic [FP_W-1:0]  src_eff;
    logic [CAT_W-1:0] cat;
    logic             src_is_nan;
    logic [TOK_W-1:0] tok;
    logic [FP_W-1:0]  res_next;

    fixup_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
        .src_raw    (src_in),
        .daz_en     (daz_en),
        .src_eff    (src_eff),
        .cat        (cat),
        .src_is_nan (src_is_nan)
    );

    fixup_tok_pick #(.TOK_W(TOK_W), .CAT_N(CAT_N)) u_tok_pick (
        .ctrl_word (ctrl_word),
        .cat       (cat),
        .tok       (tok)
    );

    fixup_value_gen #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_value_gen (
        .tok        (tok),
        .dst        (dst_in),
        .src_eff    (src_eff),
        .src_is_nan (src_is_nan),
        .value      (res_next)
    );

    // Output stage: capture the result on a request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_out   <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                res_out <= res_next;
        end
    end

    // R8: a request produces a valid result one cycle later.
    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R8: no request, no valid result next cycle.
    a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    // R9: the result holds while no request is presented.
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_out));

    // R4: token 0 returns the destination operand of the request.
    a_r4_keep_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tok == TOK_W'(0)) |=> (res_out == $past(dst_in)));

endmodule

// File: tb/fp_fixup_unit_bench.sv
// Bench: directed corners, a full class-by-token sweep, then seeded random.
module fp_fixup_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] dst_in;
    logic [63:0] src_in;
    logic [31:0] ctrl_word;
    logic        daz_en;
    logic [63:0] res_out;
    logic        res_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_fixup_unit u_fp_fixup_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dst_in    (dst_in),
        .src_in    (src_in),
        .ctrl_word (ctrl_word),
        .daz_en    (daz_en),
        .res_out   (res_out),
        .res_valid (res_valid)
    );

    function automatic int ref_class(input logic [63:0] s);
        if (s[62:52] == 11'h7FF && s[51:0] != 0) return s[51] ? 0 : 1;
        if (s[62:0] == 0) return 2;
        if (s == 64'h3FF0000000000000) return 3;
        if (s[62:52] == 11'h7FF) return s[63] ? 4 : 5;
        return s[63] ? 6 : 7;
    endfunction

    function automatic logic [63:0] ref_flush(input logic [63:0] s, input logic z);
        if (z && s[62:52] == 0 && s[51:0] != 0) return {s[63], 63'b0};
        return s;
    endfunction

    function automatic logic [63:0] ref_fix(input logic [63:0] d, input logic [63:0] s0,
                                            input logic [31:0] c, input logic z);
        logic [63:0] s;
        logic [3:0]  t;
        int          k;
        s = ref_flush(s0, z);
        k = ref_class(s);
        t = c[k*4 +: 4];
        case (t)
            4'h0: return d;
            4'h1: return s;
            4'h2: return (k <= 1) ? (s | 64'h0008000000000000) : 64'hFFF8000000000000;
            4'h3: return 64'hFFF8000000000000;
            4'h4: return 64'hFFF0000000000000;
            4'h5: return 64'h7FF0000000000000;
            4'h6: return s[63] ? 64'hFFF0000000000000 : 64'h7FF0000000000000;
            4'h7: return 64'h8000000000000000;
            4'h8: return 64'h0;
            4'h9: return 64'hBFF0000000000000;
            4'hA: return 64'h3FF0000000000000;
            4'hB: return 64'h3FE0000000000000;
            4'hC: return 64'h4056800000000000;
            4'hD: return 64'h3FF921FB54442D18;
            4'hE: return 64'h7FEFFFFFFFFFFFFF;
            default: return 64'hFFEFFFFFFFFFFFFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one request at the falling edge, sample just after the capture edge.
    task automatic apply(input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] c, input logic z, input string req);
        @(negedge clk);
        in_valid = 1'b1; dst_in = d; src_in = s; ctrl_word = c; daz_en = z;
        @(posedge clk);
        #1;
        chk(req, res_out, ref_fix(d, s, c, z));
        chk({req, " R8 valid"}, {63'b0, res_valid}, 64'd1);
    endtask

    function automatic logic [63:0] pick_src(input int sel, input logic [63:0] r);
        case (sel)
            0: return {r[63], 11'h7FF, 1'b1, r[50:0]};
            1: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
            2: return {r[63], 63'b0};
            3: return 64'h3FF0000000000000;
            4: return {r[63], 11'h7FF, 52'b0};
            5: return {r[63], 11'h0, r[51:1], 1'b1};
            6: return 64'hBFF0000000000000;
            default: return r;
        endcase
    endfunction

    logic [63:0] samples [8];

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        samples[0] = 64'h7FF8000000001234;
        samples[1] = 64'hFFF0000000000055;
        samples[2] = 64'h8000000000000000;
        samples[3] = 64'h3FF0000000000000;
        samples[4] = 64'hFFF0000000000000;
        samples[5] = 64'h7FF0000000000000;
        samples[6] = 64'hC004000000000000;
        samples[7] = 64'h4000000000000000;

        rst_n = 1'b0; in_valid = 1'b1; dst_in = '1; src_in = '1;
        ctrl_word = 32'hFFFFFFFF; daz_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset res_out", res_out, 64'h0);
        chk("R10 reset res_valid", {63'b0, res_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;

        // R2/R1: zero to -0 word, both zero signs and a nonzero value.
        apply(64'h1111, 64'h0000000000000000, 32'h00000700, 1'b0, "R2 +0 to -0");
        chk("R2 +0 to -0 direct", res_out, 64'h8000000000000000);
        apply(64'h1111, 64'h8000000000000000, 32'h00000700, 1'b0, "R2 -0 to -0");
        apply(64'h2222, 64'h4000000000000000, 32'h00000700, 1'b0, "R4 other kept dst");
        chk("R4 other kept dst direct", res_out, 64'h2222);
        // R6: infinity swap word.
        apply(64'h3333, 64'hFFF0000000000000, 32'h00450000, 1'b0, "R6 -inf to +inf");
        chk("R6 swap direct", res_out, 64'h7FF0000000000000);
        apply(64'h3333, 64'h7FF0000000000000, 32'h00450000, 1'b0, "R6 +inf to -inf");
        apply(64'h4444, 64'hC000000000000000, 32'h00450000, 1'b0, "R6 finite kept");
        // R11: -1.0 is a negative value, +1.0 is class 3.
        apply(64'h0, 64'hBFF0000000000000, 32'h0A000000, 1'b0, "R11 -1.0 class6");
        chk("R11 -1.0 direct", res_out, 64'h3FF0000000000000);
        apply(64'h0, 64'h3FF0000000000000, 32'h0000B000, 1'b0, "R11 +1.0 class3");
        chk("R11 +1.0 direct", res_out, 64'h3FE0000000000000);
        // R3: subnormal with and without flush.
        apply(64'h5, 64'h800000000000ABCD, 32'h00000110, 1'b1, "R3 flushed pass");
        chk("R3 flushed pass direct", res_out, 64'h8000000000000000);
        apply(64'h5, 64'h800000000000ABCD, 32'h01000000, 1'b0, "R3 unflushed class6");
        chk("R3 unflushed direct", res_out, 64'h800000000000ABCD);
        // R5: quieting keeps sign and payload.
        apply(64'h0, 64'hFFF0000000000055, 32'h00000020, 1'b0, "R5 quiet snan");
        chk("R5 quiet direct", res_out, 64'hFFF8000000000055);

        // R9: idle cycles hold the result.
        held = res_out;
        @(negedge clk);
        in_valid = 1'b0; src_in = 64'h7FF0000000000000; ctrl_word = 32'h55555555;
        @(posedge clk); #1;
        chk("R9 hold", res_out, held);
        chk("R8 idle not valid", {63'b0, res_valid}, 64'd0);
        @(posedge clk); #1;
        chk("R9 hold second cycle", res_out, held);

        // R1 R4 R5 R6 R7: every class against every token, flush on and off.
        for (int z = 0; z < 2; z++)
            for (int k = 0; k < 8; k++)
                for (int t = 0; t < 16; t++)
                    apply(64'h0123456789ABCDEF, samples[k], {8{4'(t)}}, z[0],
                          "R1 R7 sweep");

        // R2 R3: seeded random mix biased to special values.
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            apply({$urandom, $urandom}, pick_src(int'($urandom % 9), r),
                  $urandom, 1'($urandom), "R2 R3 random");
        end

        @(negedge clk);
        in_valid = 1'b0;
        finish_run();
    end

endmodule